// File: doc/BRIEF.md
# Ultra DMA Host Burst Engine

This block runs the host end of an Ultra DMA data burst once the device has opened it. In the write-to-disk direction it takes 16-bit words from a valid/ready stream, places each on the outgoing data bus and flips a host write strobe, so that every rising and every falling strobe edge marks one new word. In the read-from-disk direction it watches the device-driven read strobe through a synchronizer. It captures the data bus on both edges of that strobe and pushes each word into a small receive FIFO, which drains into a valid/ready output stream.

Pausing differs by direction. In a write burst the device lowers its ready input, and the host then stops flipping its strobe. In a read burst the host lowers its own ready output once the receive FIFO is close to full. The host ends either kind of burst by raising its stop output. It then waits until the read strobe has been quiet for a set number of clocks and returns to idle. A counter reports how many words moved in the current burst.

The controller has five states. IDLE waits for `start`. WR_LOAD takes the next stream word onto the bus. WR_HOLD keeps that word stable and toggles the strobe. RD_RUN captures device words. STOP drives the stop line until the strobe has gone quiet. The transitions are:
- IDLE→WR_LOAD when `start` is high with `dir_write` set.
- IDLE→RD_RUN when `start` is high with `dir_write` clear.
- WR_LOAD→WR_HOLD when a word is taken.
- WR_HOLD→WR_LOAD when the strobe toggles.
- WR_LOAD→STOP and RD_RUN→STOP on `end_req`.
- STOP→IDLE once the quiet window has run out.

Top module: `udma_host_burst`

## Requirements
- R1: After reset the block is idle. `busy`, `host_stop`, `host_rdy`, `tx_ready`, `rx_valid` and `word_count` are 0, and `wr_strobe` is 1.
- R2: In a write burst, each change of `wr_strobe` presents the next accepted stream word on `bus_dout`, in stream order. The first change of a burst goes from 1 to 0, because `start` sets the strobe high.
- R3: A word is on `bus_dout` unchanged for at least HOLD_CLKS clocks (default 3) before the strobe change that marks it, and it does not change at that change.
- R4: While `dev_rdy` is low, `wr_strobe` does not change. The word already loaded stays on `bus_dout`, and the transfer resumes in order when `dev_rdy` rises.
- R5: In a read burst, each rising and each falling edge of `rd_strobe` captures `bus_din` into the receive stream. Words leave on `rx_data` in capture order, and they are held while `rx_valid` is high and `rx_ready` is low.
- R6: `host_rdy` is high in RD_RUN only while the receive FIFO (RX_DEPTH entries, default 16) has more than RDY_MARGIN (default 4) free entries. With no draining, exactly 12 words fit before it drops, and it rises again once one word is drained.
- R7: `end_req` moves the block to STOP, where `host_stop` is 1 and `tx_ready` and `host_rdy` are 0. No further stream word is accepted, and every accepted word has been strobed.
- R8: In STOP, read-strobe edges that are still in flight are still captured. The block returns to IDLE and drops `host_stop` after QUIET_CLKS clocks (default 8) with no read-strobe edge.
- R9: `word_count` rises by one for each word strobed out or captured, and it clears to 0 when a burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, much faster than the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Burst begins (sampled in IDLE) |
| dir_write | input | 1 | 1 = write to disk, 0 = read from disk, taken with `start` |
| end_req | input | 1 | Level request to end the burst |
| tx_data | input | 16 | Outgoing stream word |
| tx_valid | input | 1 | Outgoing stream word valid |
| tx_ready | output | 1 | Outgoing word taken this clock |
| bus_dout | output | 16 | Data driven to the device |
| wr_strobe | output | 1 | Host write strobe, one word per edge |
| dev_rdy | input | 1 | Device ready, low pauses a write burst |
| rd_strobe | input | 1 | Device read strobe, one word per edge |
| bus_din | input | 16 | Data driven by the device |
| host_rdy | output | 1 | Host ready, low pauses a read burst |
| host_stop | output | 1 | Host stop line, high ends the burst |
| rx_data | output | 16 | Received stream word |
| rx_valid | output | 1 | Received word valid |
| rx_ready | input | 1 | Consumer takes the received word |
| word_count | output | 16 | Words moved in the current burst |
| busy | output | 1 | Block is not idle |

## Verification
The bench goes after strobe edge cases. The first strobe change of a burst must fall. An odd number of read words must be captured on both edges. After an odd-length write burst the strobe must be restored without being counted as a word. A design that misses either edge would lose every other read word, and one that forgets to restore the strobe would start the next write burst with a rising edge.

The bench also targets the read pause margin. With the consumer stalled, exactly 12 words must land before `host_rdy` falls. An off-by-one margin would allow 11 or 13 words.

Stopping is the last target. A stop raised during a held word must still strobe that word, and no stream word may be taken afterward. A word launched by the device after stop must still arrive, and idle must follow only after the quiet window. A design that accepts on stop would drop data, and one that leaves too early would miss the in-flight word.

// File: rtl/udma_host_pkg.sv
package udma_host_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LOAD,
        ST_WR_HOLD,
        ST_RD_RUN,
        ST_STOP
    } burst_state_t;
endpackage

// File: rtl/udma_strobe_sync.sv
module udma_strobe_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_in,
    input  logic [W-1:0] data_in,
    output logic         edge_seen,
    output logic [W-1:0] data_out
);
    logic         s1, s2, s3;
    logic [W-1:0] d1, d2;

    // Data travels beside the strobe so both arrive aligned.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
            d1 <= '0;
            d2 <= '0;
        end else begin
            s1 <= strobe_in;
            s2 <= s1;
            s3 <= s2;
            d1 <= data_in;
            d2 <= d1;
        end
    end

    assign edge_seen = s2 ^ s3;
    assign data_out  = d2;
endmodule

// File: rtl/udma_rx_fifo.sv
module udma_rx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    output logic [W-1:0]               out_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [$clog2(DEPTH+1)-1:0] free
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign out_valid = (cnt != '0);
    assign do_pop    = out_valid && out_ready;
    assign do_push   = push && (cnt != FULL_V);
    assign out_data  = mem[rp];
    assign free      = FULL_V - cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/udma_host_burst.sv
module udma_host_burst
    import udma_host_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int RX_DEPTH   = 16,
    parameter int RDY_MARGIN = 4,
    parameter int HOLD_CLKS  = 3,
    parameter int QUIET_CLKS = 8,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_write,
    input  logic              end_req,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] bus_dout,
    output logic              wr_strobe,
    input  logic              dev_rdy,
    input  logic              rd_strobe,
    input  logic [WORD_W-1:0] bus_din,
    output logic              host_rdy,
    output logic              host_stop,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [CNT_W-1:0]  word_count,
    output logic              busy
);
    localparam int FW = $clog2(RX_DEPTH + 1);
    localparam int HW = $clog2(HOLD_CLKS + 1);
    localparam int QW = $clog2(QUIET_CLKS + 1);
    localparam logic [FW-1:0] MARGIN_V  = FW'(RDY_MARGIN);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CLKS - 1);
    localparam logic [QW-1:0] QUIET_END = QW'(QUIET_CLKS - 1);

    burst_state_t      st, nxt;
    logic [HW-1:0]     hold_cnt;
    logic [QW-1:0]     quiet_cnt;
    logic              dir_q;
    logic              rd_edge;
    logic [WORD_W-1:0] rd_word;
    logic [FW-1:0]     rx_free;
    logic              push, hold_done, quiet_done, fire;

    udma_strobe_sync #(.W(WORD_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_in(rd_strobe),
        .data_in  (bus_din),
        .edge_seen(rd_edge),
        .data_out (rd_word)
    );

    udma_rx_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(rd_word),
        .out_data (rx_data),
        .out_valid(rx_valid),
        .out_ready(rx_ready),
        .free     (rx_free)
    );

    assign hold_done  = (hold_cnt == HOLD_LAST);
    assign quiet_done = (quiet_cnt == QUIET_END) && !rd_edge;
    assign fire       = (st == ST_WR_HOLD) && hold_done && dev_rdy;
    assign push       = rd_edge && !dir_q && (rx_free != '0)
                        && ((st == ST_RD_RUN) || (st == ST_STOP));
    assign tx_ready   = (st == ST_WR_LOAD) && !end_req;
    assign host_rdy   = (st == ST_RD_RUN) && (rx_free > MARGIN_V);
    assign busy       = (st != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:    if (start) nxt = dir_write ? ST_WR_LOAD : ST_RD_RUN;
            ST_WR_LOAD: if (end_req) nxt = ST_STOP;
                        else if (tx_valid) nxt = ST_WR_HOLD;
            ST_WR_HOLD: if (hold_done && dev_rdy) nxt = ST_WR_LOAD;
            ST_RD_RUN:  if (end_req) nxt = ST_STOP;
            ST_STOP:    if (quiet_done) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_dout   <= '0;
            wr_strobe  <= 1'b1;
            hold_cnt   <= '0;
            quiet_cnt  <= '0;
            word_count <= '0;
            host_stop  <= 1'b0;
            dir_q      <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        word_count <= '0;
                        wr_strobe  <= 1'b1;
                        dir_q      <= dir_write;
                    end
                end
                ST_WR_LOAD: begin
                    hold_cnt <= '0;
                    if (tx_ready && tx_valid) bus_dout <= tx_data;
                end
                ST_WR_HOLD: begin
                    if (!hold_done) hold_cnt <= hold_cnt + 1'b1;
                    if (fire) begin
                        wr_strobe  <= ~wr_strobe;
                        word_count <= word_count + 1'b1;
                    end
                end
                ST_RD_RUN: begin
                    if (push) word_count <= word_count + 1'b1;
                end
                ST_STOP: begin
                    if (push) word_count <= word_count + 1'b1;
                    if (rd_edge)         quiet_cnt <= '0;
                    else if (!quiet_done) quiet_cnt <= quiet_cnt + 1'b1;
                    if (quiet_done) host_stop <= 1'b0;
                end
                default: ;
            endcase
            if (nxt == ST_STOP && st != ST_STOP) begin
                host_stop <= 1'b1;
                quiet_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/udma_host_burst_chk.sv
module udma_host_burst_chk #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              dev_rdy,
    input logic              wr_strobe,
    input logic [WORD_W-1:0] bus_dout,
    input logic              tx_ready,
    input logic              host_stop,
    input logic              host_rdy,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [WORD_W-1:0] rx_data,
    input logic [CNT_W-1:0]  word_count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_toggle_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_strobe != $past(wr_strobe)) && !$past(start)) |-> $past(dev_rdy));

    assert_bus_stable_at_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_strobe != $past(wr_strobe)) && !$past(start)) |-> $stable(bus_dout));

    assert_no_accept_in_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_stop |-> (!tx_ready && !host_rdy));

    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count != $past(word_count)) |->
        ((word_count == $past(word_count) + ONE) || (word_count == '0)));
endmodule

bind udma_host_burst udma_host_burst_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dev_rdy   (dev_rdy),
    .wr_strobe (wr_strobe),
    .bus_dout  (bus_dout),
    .tx_ready  (tx_ready),
    .host_stop (host_stop),
    .host_rdy  (host_rdy),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .word_count(word_count)
);

// File: tb/sim_udma_host_burst.sv
module sim_udma_host_burst;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 3;
    localparam int QUIET = 8;

    logic        clk = 0, rst_n = 0;
    logic        start = 0, dir_write = 0, end_req = 0;
    logic [15:0] tx_data;
    logic        tx_valid, tx_ready;
    logic [15:0] bus_dout, bus_din = 0, rx_data, word_count;
    logic        wr_strobe, dev_rdy = 1, rd_strobe = 0;
    logic        host_rdy, host_stop, rx_valid, rx_ready = 0, busy;

    int checks = 0, fails = 0;
    logic [15:0] words [32];
    logic [15:0] rx_exp [32];
    int tx_idx = 0, tx_n = 0;
    int tog_n = 0, stable_cnt = 0, rx_n = 0;
    logic [15:0] last_bus = 0;
    logic last_strb = 1, last_busy = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    udma_host_burst u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write), .end_req(end_req),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .bus_dout(bus_dout), .wr_strobe(wr_strobe), .dev_rdy(dev_rdy),
        .rd_strobe(rd_strobe), .bus_din(bus_din), .host_rdy(host_rdy), .host_stop(host_stop),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .word_count(word_count), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Outgoing stream source
    assign tx_valid = (tx_idx < tx_n);
    assign tx_data  = words[tx_idx[4:0]];
    always @(posedge clk) if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;

    // Received stream sink
    always @(posedge clk) begin
        if (rx_valid && rx_ready) begin
            check(rx_data == rx_exp[rx_n[4:0]], "R5 rx order", rx_data, rx_exp[rx_n[4:0]]);
            rx_n = rx_n + 1;
        end
    end

    // Write strobe monitor
    always @(negedge clk) begin
        if (bus_dout != last_bus) stable_cnt = 1; else stable_cnt = stable_cnt + 1;
        last_bus = bus_dout;
        if (wr_strobe != last_strb && last_busy) begin
            check(bus_dout == words[tog_n[4:0]], "R2 word order", bus_dout, words[tog_n[4:0]]);
            check(stable_cnt - 1 >= HOLD, "R3 hold time", stable_cnt - 1, HOLD);
            if (tog_n == 0) check(wr_strobe == 1'b0, "R2 first edge falls", wr_strobe, 0);
            tog_n = tog_n + 1;
        end
        last_strb = wr_strobe;
        last_busy = busy;
    end

    task automatic go(input bit wr);
        @(negedge clk); start = 1; dir_write = wr;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 200) begin @(negedge clk); n++; end
        check(!busy, req, busy, 0);
    endtask

    task automatic wait_tog(input int target);
        int n = 0;
        while (tog_n < target && n < 2000) begin @(posedge clk); n++; end
        check(tog_n >= target, "R2 toggles reached", tog_n, target);
    endtask

    task automatic finish_burst();
        @(negedge clk); end_req = 1;
        wait_idle("R8 back to idle");
        end_req = 0;
    endtask

    task automatic dev_word(input logic [15:0] w, input bit force_it, output bit sent);
        @(negedge clk); bus_din = w;
        @(negedge clk);
        @(negedge clk);
        sent = force_it || host_rdy;
        if (sent) rd_strobe = ~rd_strobe;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(!busy && !host_stop && !host_rdy && !tx_ready, "R1 idle outputs", busy, 0);
        check(wr_strobe == 1'b1, "R1 strobe high", wr_strobe, 1);
        check(!rx_valid && word_count == 0, "R1 rx and count", word_count, 0);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_write_basic();
        for (int i = 0; i < 6; i++) words[i] = 16'h1000 + 16'(i * 17 + 1);
        tx_idx = 0; tx_n = 6; tog_n = 0;
        go(1);
        wait_tog(6);
        @(negedge clk);
        check(word_count == 6, "R9 write count", word_count, 6);
        check(tx_idx == 6, "R2 all taken", tx_idx, 6);
        finish_burst();
    endtask

    task automatic t_write_pause();
        int pre;
        for (int i = 0; i < 8; i++) words[i] = 16'h2200 + 16'(i * 3 + 5);
        tx_idx = 0; tx_n = 8; tog_n = 0;
        go(1);
        wait_tog(3);
        @(negedge clk); dev_rdy = 0;
        pre = tog_n;
        repeat (20) @(negedge clk);
        check(tog_n == pre, "R4 no toggle while paused", tog_n, pre);
        check(bus_dout == words[pre], "R4 word held", bus_dout, words[pre]);
        dev_rdy = 1;
        wait_tog(8);
        @(negedge clk);
        check(word_count == 8, "R4 resumed count", word_count, 8);
        finish_burst();
    endtask

    task automatic t_write_stop();
        int n = 0, tg, acc;
        for (int i = 0; i < 10; i++) words[i] = 16'h3300 + 16'(i * 7 + 2);
        tx_idx = 0; tx_n = 10; tog_n = 0;
        go(1);
        wait_tog(3);
        @(negedge clk); end_req = 1;
        while (!host_stop && n < 100) begin @(negedge clk); n++; end
        check(host_stop, "R7 stop raised", host_stop, 1);
        tg = tog_n; acc = tx_idx;
        check(acc == tg, "R7 accepted all strobed", acc, tg);
        repeat (4) @(negedge clk);
        check(tog_n == tg && tx_idx == acc && !tx_ready, "R7 no accept after stop", tx_idx, acc);
        wait_idle("R8 write stop idle");
        check(!host_stop, "R8 stop dropped", host_stop, 0);
        end_req = 0;
        tx_n = 0;
    endtask

    task automatic t_read_basic();
        bit s;
        int n = 0;
        for (int i = 0; i < 8; i++) rx_exp[i] = 16'h4400 + 16'(i * 11 + 3);
        rx_n = 0; rx_ready = 1;
        go(0);
        for (int i = 0; i < 7; i++) dev_word(rx_exp[i], 0, s);
        while (rx_n < 7 && n < 100) begin @(negedge clk); n++; end
        check(rx_n == 7, "R5 both edges captured", rx_n, 7);
        check(word_count == 7, "R9 read count", word_count, 7);
        @(negedge clk); end_req = 1;
        dev_word(rx_exp[7], 1, s);
        check(host_stop && !host_rdy, "R7 read stop", host_stop, 1);
        wait_idle("R8 read idle");
        end_req = 0;
        check(rx_n == 8, "R8 in-flight word kept", rx_n, 8);
        check(word_count == 8, "R8 count includes in-flight", word_count, 8);
    endtask

    task automatic t_read_pause();
        bit s;
        int sent = 0, n = 0;
        for (int i = 0; i < 20; i++) rx_exp[i] = 16'h5500 + 16'(i * 13 + 1);
        rx_n = 0; rx_ready = 0;
        go(0);
        @(negedge clk);
        check(word_count == 0, "R9 clear at start", word_count, 0);
        for (int i = 0; i < 20; i++) begin
            dev_word(rx_exp[sent], 0, s);
            if (s) sent++; else break;
        end
        check(sent == 12, "R6 words before pause", sent, 12);
        check(!host_rdy, "R6 ready low", host_rdy, 0);
        rx_ready = 1;
        repeat (3) @(negedge clk);
        check(host_rdy, "R6 ready back", host_rdy, 1);
        while (rx_n < 12 && n < 100) begin @(negedge clk); n++; end
        check(rx_n == 12, "R5 drained all", rx_n, 12);
        finish_burst();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write_basic();
        t_write_pause();
        t_write_stop();
        t_read_basic();
        t_read_pause();
        repeat (5) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule